// File: doc/BRIEF.md
# I2C Controller Interrupt Status and FIFO Flush Unit

This unit gathers every interrupt source of an I2C controller into one status word and drives a single interrupt line. Some sources are levels that follow the FIFOs. These are empty and full for both FIFOs, transmit nearly-empty and receive nearly-full. Their comparisons use two programmable 4-bit thresholds. The other sources are sticky events. These are transmit overrun, the three slave events, master done, master done without stop, slave done, arbitration lost and bus error. An event stays set until software writes a one to its position in the clear register. A mask register selects which status bits reach the interrupt line.

The unit also sequences the flush of the two FIFOs. Writing a one to the transmit flush bit (bit 7) or the receive flush bit (bit 8) of the control word starts a fixed-length flush of that FIFO. A small state machine handles each FIFO, with states `FL_IDLE`, `FL_DRAIN` and `FL_DONE`. A start write moves it from `FL_IDLE` to `FL_DRAIN`. When the drain counter reaches `FLUSH_CYC-1`, it moves from `FL_DRAIN` to `FL_DONE`. From `FL_DONE` it always returns to `FL_IDLE` on the next cycle. The flush output to the FIFO is high in `FL_DRAIN`. The control bit reads one in `FL_DRAIN` and `FL_DONE`, and it then clears itself.

Register addresses are 0 control, 1 transmit threshold, 2 receive threshold, 3 mask, 4 raw status (read-only), 5 masked status (read-only) and 6 clear (write-only, reads 0). Reads are combinational on `reg_addr`. Writes take effect at the clock edge on which `reg_wr` is high.

Top module: `i2c_irq_fifo_ctrl`

## Requirements
- R1: The level bits follow occupancy in the same cycle and cannot be cleared. Bit 0 is set when the TX level is 0, bit 2 when the TX level equals DEPTH (16), bit 4 when the RX level is 0 and bit 6 when the RX level equals DEPTH.
- R2: Bit 1 (TX nearly empty) is set while the TX level is at or below the transmit threshold. The transmit threshold is held in `reg_wdata[3:0]` at address 1.
- R3: Bit 5 (RX nearly full) is set while the RX level is at or above the receive threshold. The receive threshold is held in `reg_wdata[3:0]` at address 2 and accepts values up to 15.
- R4: Bit 3 (TX overrun) is set in the cycle after `tx_write` is high while the TX level equals DEPTH. A write at a lower level does not set it. Once set, it stays set.
- R5: Sequencer events set their sticky bits in the cycle after the pulse. The mapping is `evt_slave[2:0]` to bits 16 to 18, master done to 19, slave done to 20, arbitration lost to 24, bus error to 25 and master done without stop to 28.
- R6: Writing to address 6 clears each sticky bit written as one. Bits written as zero, level bits and reserved bits are unaffected.
- R7: When a sticky event arrives in the same cycle as a clear of its bit, the bit stays set.
- R8: Only the positions in 0x131F007F of the mask register are writable, and the other positions read 0. Address 5 reads raw status AND mask.
- R9: `irq_o` is high exactly when some masked status bit is set.
- R10: A write of one to bit 7 (TX) or bit 8 (RX) at address 0 holds that flush output high for FLUSH_CYC (4) cycles starting the cycle after the write. The control bit reads one for FLUSH_CYC+1 cycles and then reads zero.
- R11: While a flush is running, writing the flush bit again neither restarts nor cancels it, whether the bit is written as one or zero.
- R12: After reset, the mask, both thresholds, the sticky bits and the control word are zero. With empty FIFOs the raw status is therefore 0x33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_level | input | 5 | TX FIFO occupancy |
| rx_level | input | 5 | RX FIFO occupancy |
| tx_write | input | 1 | Write strobe into the TX FIFO |
| evt_slave | input | 3 | Slave sequencer event pulses |
| evt_mst_done | input | 1 | Master transaction done pulse |
| evt_slv_done | input | 1 | Slave transaction done pulse |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_bus_err | input | 1 | Bus error pulse |
| evt_mst_done_nostop | input | 1 | Master done without stop pulse |
| tx_flush_o | output | 1 | Flush command to the TX FIFO |
| rx_flush_o | output | 1 | Flush command to the RX FIFO |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a clear that lands in the same cycle as the event it clears. The bench sets up this collision by raising the bus error pulse and the clear write in the same cycle. It then reads back a set bit, and a clear issued on its own afterwards removes the bit. A second hard case is a re-write of the flush bit during the drain. The bench issues this write in the first drain cycle and checks that the flush output falls exactly when an undisturbed flush would have ended.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int unsigned STAT_W = 32;

    // status bit positions
    localparam int unsigned B_TXE  = 0;
    localparam int unsigned B_TXNE = 1;
    localparam int unsigned B_TXF  = 2;
    localparam int unsigned B_TXOV = 3;
    localparam int unsigned B_RXE  = 4;
    localparam int unsigned B_RXNF = 5;
    localparam int unsigned B_RXF  = 6;
    localparam int unsigned B_SLV0 = 16;
    localparam int unsigned B_MDN  = 19;
    localparam int unsigned B_SDN  = 20;
    localparam int unsigned B_ARB  = 24;
    localparam int unsigned B_BERR = 25;
    localparam int unsigned B_MDNS = 28;

    localparam logic [STAT_W-1:0] IMPL_MASK   = 32'h131F_007F;
    localparam logic [STAT_W-1:0] STICKY_MASK = 32'h131F_0008;

    // control word flush positions
    localparam int unsigned C_TXFL = 7;
    localparam int unsigned C_RXFL = 8;
    localparam int unsigned N_FIFO = 2;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_TXTHR = 3'd1,
        RA_RXTHR = 3'd2,
        RA_MASK  = 3'd3,
        RA_RAW   = 3'd4,
        RA_MSKD  = 3'd5,
        RA_CLR   = 3'd6
    } reg_addr_e;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_DRAIN = 2'd1,
        FL_DONE  = 2'd2
    } flush_state_e;

endpackage

// File: rtl/i2c_flush_seq.sv
module i2c_flush_seq
    import i2c_irq_pkg::*;
#(
    parameter int unsigned FLUSH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic flush_o,
    output logic pend_o
);
    localparam int unsigned CNT_W = $clog2(FLUSH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLUSH_CYC - 1);

    flush_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == FL_DRAIN) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (start_i) state_d = FL_DRAIN;
            FL_DRAIN: if (cnt_q == CNT_LAST) state_d = FL_DONE;
            FL_DONE:  state_d = FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flush_o = 1'b0;
        pend_o  = 1'b0;
        unique case (state_q)
            FL_IDLE:  ;
            FL_DRAIN: begin flush_o = 1'b1; pend_o = 1'b1; end
            FL_DONE:  pend_o = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned THR_W = 4,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic              tx_write,
    input  logic [2:0]        evt_slave,
    input  logic              evt_mst_done,
    input  logic              evt_slv_done,
    input  logic              evt_arb_lost,
    input  logic              evt_bus_err,
    input  logic              evt_mst_done_nostop,
    input  logic              clr_stb,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] raw_o
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic [STAT_W-1:0] lvl_vec, evt_vec, clr_vec, sticky_q;

    always_comb begin
        lvl_vec         = '0;
        lvl_vec[B_TXE]  = (tx_level == '0);
        lvl_vec[B_TXNE] = (tx_level <= LVL_W'(tx_thr));
        lvl_vec[B_TXF]  = (tx_level == LVL_FULL);
        lvl_vec[B_RXE]  = (rx_level == '0);
        lvl_vec[B_RXNF] = (rx_level >= LVL_W'(rx_thr));
        lvl_vec[B_RXF]  = (rx_level == LVL_FULL);
    end

    always_comb begin
        evt_vec              = '0;
        evt_vec[B_TXOV]      = tx_write && (tx_level == LVL_FULL);
        evt_vec[B_SLV0 +: 3] = evt_slave;
        evt_vec[B_MDN]       = evt_mst_done;
        evt_vec[B_SDN]       = evt_slv_done;
        evt_vec[B_ARB]       = evt_arb_lost;
        evt_vec[B_BERR]      = evt_bus_err;
        evt_vec[B_MDNS]      = evt_mst_done_nostop;
    end

    assign clr_vec = clr_stb ? (clr_data & STICKY_MASK) : '0;

    // new events take priority over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            sticky_q <= ((sticky_q & ~clr_vec) | evt_vec) & STICKY_MASK;
        end
    end

    assign raw_o = sticky_q | lvl_vec;

endmodule

// File: rtl/i2c_irq_fifo_ctrl.sv
module i2c_irq_fifo_ctrl
    import i2c_irq_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned THR_W     = 4,
    parameter int unsigned FLUSH_CYC = 4,
    parameter int unsigned LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_write,
    input  logic [2:0]        evt_slave,
    input  logic              evt_mst_done,
    input  logic              evt_slv_done,
    input  logic              evt_arb_lost,
    input  logic              evt_bus_err,
    input  logic              evt_mst_done_nostop,
    output logic              tx_flush_o,
    output logic              rx_flush_o,
    output logic              irq_o
);
    logic [THR_W-1:0]  tx_thr_q, rx_thr_q;
    logic [STAT_W-1:0] mask_q, raw_w, masked_w;
    logic [N_FIFO-1:0] flush_vec, flush_pend;
    logic              clr_stb, ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
    assign clr_stb = reg_wr && (reg_addr == RA_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
            mask_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == RA_TXTHR) tx_thr_q <= reg_wdata[THR_W-1:0];
            if (reg_addr == RA_RXTHR) rx_thr_q <= reg_wdata[THR_W-1:0];
            if (reg_addr == RA_MASK)  mask_q   <= reg_wdata & IMPL_MASK;
        end
    end

    i2c_irq_status #(
        .DEPTH (DEPTH),
        .THR_W (THR_W),
        .LVL_W (LVL_W)
    ) status_i (
        .clk                 (clk),
        .rst_n               (rst_n),
        .tx_level            (tx_level),
        .rx_level            (rx_level),
        .tx_thr              (tx_thr_q),
        .rx_thr              (rx_thr_q),
        .tx_write            (tx_write),
        .evt_slave           (evt_slave),
        .evt_mst_done        (evt_mst_done),
        .evt_slv_done        (evt_slv_done),
        .evt_arb_lost        (evt_arb_lost),
        .evt_bus_err         (evt_bus_err),
        .evt_mst_done_nostop (evt_mst_done_nostop),
        .clr_stb             (clr_stb),
        .clr_data            (reg_wdata),
        .raw_o               (raw_w)
    );

    for (genvar g = 0; g < N_FIFO; g++) begin : g_flush
        i2c_flush_seq #(
            .FLUSH_CYC (FLUSH_CYC)
        ) seq_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (ctrl_wr && reg_wdata[C_TXFL + g]),
            .flush_o (flush_vec[g]),
            .pend_o  (flush_pend[g])
        );
    end

    assign tx_flush_o = flush_vec[0];
    assign rx_flush_o = flush_vec[1];

    assign masked_w = raw_w & mask_q;
    assign irq_o    = |masked_w;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL:  begin
                reg_rdata[C_TXFL] = flush_pend[0];
                reg_rdata[C_RXFL] = flush_pend[1];
            end
            RA_TXTHR: reg_rdata[THR_W-1:0] = tx_thr_q;
            RA_RXTHR: reg_rdata[THR_W-1:0] = rx_thr_q;
            RA_MASK:  reg_rdata = mask_q;
            RA_RAW:   reg_rdata = raw_w;
            RA_MSKD:  reg_rdata = masked_w;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_irq_fifo_chk.sv
module i2c_irq_fifo_chk
    import i2c_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_write,
    input logic [LVL_W-1:0]  tx_level,
    input logic              evt_bus_err,
    input logic              evt_mst_done,
    input logic              clr_stb,
    input logic [STAT_W-1:0] clr_data,
    input logic [STAT_W-1:0] raw,
    input logic [STAT_W-1:0] mask,
    input logic              irq_o,
    input logic              tx_flush_o,
    input logic [1:0]        pend
);
    // R4
    ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_write && tx_level == LVL_W'(DEPTH)) |=> raw[B_TXOV]);

    // R5
    berr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bus_err |=> raw[B_BERR]);

    // R6
    arb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[B_ARB] && !(clr_stb && clr_data[B_ARB])) |=> raw[B_ARB]);

    // R7
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_mst_done && clr_stb && clr_data[B_MDN]) |=> raw[B_MDN]);

    // R9
    irq_nomask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    // R10
    flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_flush_o) |=> !pend[0]);

endmodule

bind i2c_irq_fifo_ctrl i2c_irq_fifo_chk #(
    .DEPTH (DEPTH),
    .LVL_W (LVL_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_write     (tx_write),
    .tx_level     (tx_level),
    .evt_bus_err  (evt_bus_err),
    .evt_mst_done (evt_mst_done),
    .clr_stb      (clr_stb),
    .clr_data     (reg_wdata),
    .raw          (raw_w),
    .mask         (mask_q),
    .irq_o        (irq_o),
    .tx_flush_o   (tx_flush_o),
    .pend         (flush_pend)
);

// File: tb/i2c_irq_fifo_ctrl_tb_top.sv
`timescale 1ns/100ps
module i2c_irq_fifo_ctrl_tb_top;
    localparam int DEPTH = 16;
    localparam int FCYC  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  tx_level = '0;
    logic [4:0]  rx_level = '0;
    logic        tx_write = 1'b0;
    logic [2:0]  evt_slave = '0;
    logic        evt_mst_done = 1'b0, evt_slv_done = 1'b0, evt_arb_lost = 1'b0;
    logic        evt_bus_err = 1'b0, evt_mst_done_nostop = 1'b0;
    logic        tx_flush_o, rx_flush_o, irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    i2c_irq_fifo_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
        .rx_level(rx_level), .tx_write(tx_write), .evt_slave(evt_slave),
        .evt_mst_done(evt_mst_done), .evt_slv_done(evt_slv_done),
        .evt_arb_lost(evt_arb_lost), .evt_bus_err(evt_bus_err),
        .evt_mst_done_nostop(evt_mst_done_nostop), .tx_flush_o(tx_flush_o),
        .rx_flush_o(rx_flush_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle per access; called and returning just after a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    function automatic logic [31:0] lvl(input int tx, input int rx, input int tt, input int rt);
        logic [31:0] v = '0;
        v[0] = (tx == 0);
        v[1] = (tx <= tt);
        v[2] = (tx == DEPTH);
        v[4] = (rx == 0);
        v[5] = (rx >= rt);
        v[6] = (rx == DEPTH);
        return v;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd4, d); chk("R12 raw after reset", d, 32'h33);
        rd(3'd3, d); chk("R12 mask after reset", d, 0);
        rd(3'd0, d); chk("R12 ctrl after reset", d, 0);
        rd(3'd1, d); chk("R12 tx thr after reset", d, 0);
        rd(3'd5, d); chk("R12 masked after reset", d, 0);
        chk("R12 irq after reset", {31'd0, irq_o}, 0);
    endtask

    task automatic t_levels();
        logic [31:0] d;
        tx_level = 16; rx_level = 16;
        rd(3'd4, d); chk("R1 full levels", d, lvl(16, 16, 0, 0));
        wr(3'd6, 32'h0000_007F);
        rd(3'd4, d); chk("R1 level bits survive clear", d, lvl(16, 16, 0, 0));
        tx_level = 7; rx_level = 0;
        rd(3'd4, d); chk("R1 mid levels", d, lvl(7, 0, 0, 0));
    endtask

    task automatic t_thresholds();
        logic [31:0] d;
        wr(3'd1, 32'd5); wr(3'd2, 32'd9);
        for (int i = 4; i <= 6; i++) begin
            tx_level = 5'(i); rx_level = 5'(i + 4);
            rd(3'd4, d);
            chk("R2 R3 threshold compare", d, lvl(i, i + 4, 5, 9));
        end
        wr(3'd2, 32'd15);
        rx_level = 14; rd(3'd4, d); chk("R3 rx thr 15 below", d[5], 0);
        rx_level = 15; rd(3'd4, d); chk("R3 rx thr 15 at", d[5], 1);
        wr(3'd1, 32'd15);
        tx_level = 15; rd(3'd4, d); chk("R2 tx thr 15 at", d[1], 1);
        tx_level = 16; rd(3'd4, d); chk("R2 tx thr 15 above", d[1], 0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        tx_level = 15; tx_write = 1'b1; @(negedge clk); tx_write = 1'b0;
        rd(3'd4, d); chk("R4 write below full", d[3], 0);
        tx_level = 16; tx_write = 1'b1; @(negedge clk); tx_write = 1'b0;
        tx_level = 3;
        rd(3'd4, d); chk("R4 write when full", d[3], 1);
        rd(3'd4, d); chk("R4 overrun sticky", d[3], 1);
        wr(3'd6, 32'h8);
        rd(3'd4, d); chk("R6 overrun cleared", d[3], 0);
    endtask

    task automatic t_events();
        logic [31:0] d;
        int pos[8] = '{16, 17, 18, 19, 20, 24, 25, 28};
        for (int k = 0; k < 8; k++) begin
            case (k)
                0, 1, 2: evt_slave = 3'(1 << k);
                3: evt_mst_done = 1'b1;
                4: evt_slv_done = 1'b1;
                5: evt_arb_lost = 1'b1;
                6: evt_bus_err = 1'b1;
                default: evt_mst_done_nostop = 1'b1;
            endcase
            @(negedge clk);
            evt_slave = '0; evt_mst_done = 0; evt_slv_done = 0;
            evt_arb_lost = 0; evt_bus_err = 0; evt_mst_done_nostop = 0;
            rd(3'd4, d);
            chk($sformatf("R5 event to bit %0d", pos[k]), d & 32'h131F_0008, 32'(1) << pos[k]);
            rd(3'd4, d);
            chk("R5 event sticky", d[pos[k]], 1);
            wr(3'd6, 32'hFFFF_FFFF);
        end
    endtask

    task automatic t_clear();
        logic [31:0] d;
        tx_level = 16; rx_level = 16;
        wr(3'd1, 0); wr(3'd2, 0);
        evt_arb_lost = 1; evt_bus_err = 1; evt_slv_done = 1;
        @(negedge clk);
        evt_arb_lost = 0; evt_bus_err = 0; evt_slv_done = 0;
        wr(3'd6, 32'h0100_0000);
        rd(3'd4, d);
        chk("R6 partial clear", d, lvl(16, 16, 0, 0) | 32'h0210_0000);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd4, d);
        chk("R6 full clear keeps levels", d, lvl(16, 16, 0, 0));
    endtask

    task automatic t_collision();
        logic [31:0] d;
        evt_bus_err = 1; reg_addr = 3'd6; reg_wdata = 32'h0200_0000; reg_wr = 1;
        @(negedge clk);
        evt_bus_err = 0; reg_wr = 0; reg_wdata = '0;
        rd(3'd4, d); chk("R7 event beats clear", d[25], 1);
        wr(3'd6, 32'h0200_0000);
        rd(3'd4, d); chk("R7 later clear works", d[25], 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        tx_level = 5; rx_level = 5; wr(3'd1, 0); wr(3'd2, 15);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); chk("R8 mask writable positions", d, 32'h131F_007F);
        wr(3'd3, 32'h0100_0000);
        rd(3'd5, d); chk("R8 masked idle", d, 0);
        chk("R9 irq low", {31'd0, irq_o}, 0);
        evt_arb_lost = 1; evt_bus_err = 1; @(negedge clk); evt_arb_lost = 0; evt_bus_err = 0;
        rd(3'd5, d); chk("R8 masked equals raw and mask", d, 32'h0100_0000);
        chk("R9 irq high", {31'd0, irq_o}, 1);
        wr(3'd6, 32'h0100_0000);
        chk("R9 irq drops with other bit unmasked", {31'd0, irq_o}, 0);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd3, 0);
    endtask

    task automatic t_flush_tx();
        logic [31:0] d;
        wr(3'd0, 32'h80);
        wr(3'd0, 32'h80); // R11 rewrite during drain, now in drain cycle 1
        for (int i = 1; i < FCYC; i++) begin
            chk("R10 tx flush high", {31'd0, tx_flush_o}, 1);
            chk("R10 rx flush quiet", {31'd0, rx_flush_o}, 0);
            rd(3'd0, d); chk("R10 tx bit pending", d, 32'h80);
        end
        chk("R11 tx flush not restarted", {31'd0, tx_flush_o}, 0);
        rd(3'd0, d); chk("R10 tx bit in done", d, 32'h80);
        rd(3'd0, d); chk("R10 tx bit self-cleared", d, 0);
    endtask

    task automatic t_flush_rx();
        logic [31:0] d;
        wr(3'd0, 32'h100);
        chk("R10 rx flush starts", {31'd0, rx_flush_o}, 1);
        wr(3'd0, 32'h0); // R11 zero write does not cancel
        for (int i = 1; i < FCYC; i++) begin
            chk("R11 rx flush held", {31'd0, rx_flush_o}, 1);
            @(negedge clk);
        end
        chk("R10 rx flush ends", {31'd0, rx_flush_o}, 0);
        rd(3'd0, d); chk("R10 rx bit in done", d, 32'h100);
        rd(3'd0, d); chk("R10 rx bit self-cleared", d, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();
        t_thresholds();
        t_overrun();
        t_events();
        t_clear();
        t_collision();
        t_mask();
        t_flush_tx();
        t_flush_rx();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule